// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits on the device side of a byte-wide NOR flash and interprets the host's write cycles. Each write (address plus data byte, qualified by a one-cycle write strobe on the system clock) advances a state machine that recognises the two-write unlock prefix and the command that follows it. When a sequence completes, the decoder raises a one-cycle start pulse for byte program, whole-array erase, sector erase, erase suspend or erase resume. It also selects what a host read returns (array contents, operation status or identification codes) and keeps the set of sectors queued for erase. The embedded algorithms themselves live elsewhere and report completion on `alg_done`.

The states are: `ST_IDLE` (array reads), `ST_UNL1` and `ST_UNL2` (first and second unlock write seen), `ST_PGM_WAIT` (waiting for the program address and data), `ST_ERS1`, `ST_ERS2` and `ST_ERS3` (erase setup, second unlock pair, final erase byte), `ST_AUTOSEL` (identification reads), `ST_PGM_BUSY`, `ST_CHIP_BUSY`, `ST_SECT_WIN` (sector queueing window), `ST_SECT_BUSY` and `ST_SUSP`. Transitions: IDLE to UNL1 on the first unlock write; UNL1 to UNL2 on the second; UNL2 to PGM_WAIT, ERS1 or AUTOSEL by command byte; PGM_WAIT to PGM_BUSY (unprotected target) or IDLE; ERS1 to ERS2 to ERS3 on the repeated unlock pair; ERS3 to CHIP_BUSY or SECT_WIN; SECT_WIN to itself on each added sector, to SECT_BUSY on window expiry, to SUSP on suspend, to IDLE on any other write or an empty set; SECT_BUSY to SUSP on suspend; SUSP back to SECT_BUSY or SECT_WIN on resume; every busy state to IDLE on `alg_done`; any wrong write inside a sequence to IDLE.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `read_sel` is 0 (array), `erase_set` is all zero and no pulse output is high.
- R2: Command addresses compare only the low CMD_AW (11) address bits; the unlock prefix is 0xAA at 0x555 then 0x55 at 0x2AA, and any write that does not match the expected step returns to IDLE without a pulse.
- R3: Prefix, 0xA0 at 0x555, then a write of address A and data D raises `pgm_start` for one cycle, in the cycle after that write, with `pgm_addr`=A and `pgm_data`=D; `read_sel` is then 1 (status) until `alg_done`.
- R4: A program whose target sector (address bits [18:16]) has its `prot_mask` bit set raises no pulse and returns to IDLE.
- R5: Prefix, 0x80 at 0x555, prefix again, then 0x10 at 0x555 raises `chip_start` with `erase_set` equal to the inverted `prot_mask`; if every sector is protected no pulse is raised and `read_sel` stays 0.
- R6: The same erase sequence ending in 0x30 at any address queues that address's sector (unless protected) and opens a window; `sect_start` rises exactly WIN_CYCLES cycles after the last accepted 0x30 write when the set is non-empty, otherwise the decoder returns to IDLE with no pulse.
- R7: Every 0x30 write inside the window adds a sector and restarts the window; a 0x30 write arriving in the cycle the window would expire is taken as an addition and no erase starts then.
- R8: Any write in the window other than 0x30 or 0xB0 clears the set and returns to IDLE with no pulse.
- R9: 0xB0 during the window or a running sector erase raises `susp_pulse` and sets `read_sel` to 0; during a program or whole-array erase it is ignored and `read_sel` stays 1.
- R10: In suspend, 0x30 raises `resume_pulse` and `read_sel` becomes 1; the decoder goes back to the running erase, or, if suspended inside the window, reopens a full window; other writes are ignored.
- R11: Prefix then 0x90 at 0x555 sets `read_sel` to 2 (identification); only 0xF0 leaves it, back to 0.
- R12: `alg_done` in any busy state returns to IDLE and clears `erase_set`; it is ignored in suspend.
- R13: 0xF0 written part-way through a sequence returns to IDLE; later command bytes without a fresh prefix start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write data byte |
| prot_mask | input | N_SECT | Per-sector protection, 1 = protected |
| alg_done | input | 1 | Embedded operation finished |
| pgm_start | output | 1 | Byte program start pulse |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | 8 | Program data byte |
| chip_start | output | 1 | Whole-array erase start pulse |
| sect_start | output | 1 | Sector erase start pulse |
| susp_pulse | output | 1 | Erase suspend pulse |
| resume_pulse | output | 1 | Erase resume pulse |
| erase_set | output | N_SECT | Sectors queued or being erased |
| read_sel | output | 2 | Read path: 0 array, 1 status, 2 identification |

## Verification
The two functions that can meet in one cycle are window expiry and a further 0x30 queueing write. The bench counts cycles from the last accepted 0x30 write and places the next one so the strobe lands exactly on the expiry edge; it then expects no `sect_start` in that cycle, the new sector present in `erase_set`, and the start pulse one full window after the late write. Suspend inside the window is judged the same way: no start while suspended, and a full window after resume.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_WAIT,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_AUTOSEL,
        ST_PGM_BUSY,
        ST_CHIP_BUSY,
        ST_SECT_WIN,
        ST_SECT_BUSY,
        ST_SUSP
    } fcd_state_e;

    localparam logic [7:0]  CB_UNLOCK1 = 8'hAA;
    localparam logic [7:0]  CB_UNLOCK2 = 8'h55;
    localparam logic [7:0]  CB_PROGRAM = 8'hA0;
    localparam logic [7:0]  CB_ERASE   = 8'h80;
    localparam logic [7:0]  CB_CHIP    = 8'h10;
    localparam logic [7:0]  CB_SECTOR  = 8'h30;
    localparam logic [7:0]  CB_SUSPEND = 8'hB0;
    localparam logic [7:0]  CB_RESET   = 8'hF0;
    localparam logic [7:0]  CB_AUTOSEL = 8'h90;

    localparam logic [15:0] CA_FIRST   = 16'h0555;
    localparam logic [15:0] CA_SECOND  = 16'h02AA;

    localparam logic [1:0]  RS_ARRAY   = 2'd0;
    localparam logic [1:0]  RS_STATUS  = 2'd1;
    localparam logic [1:0]  RS_IDENT   = 2'd2;

    function automatic logic [1:0] mode_of(input fcd_state_e s);
        case (s)
            ST_AUTOSEL:   return RS_IDENT;
            ST_PGM_BUSY,
            ST_CHIP_BUSY,
            ST_SECT_WIN,
            ST_SECT_BUSY: return RS_STATUS;
            default:      return RS_ARRAY;
        endcase
    endfunction

endpackage

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match
    import fcd_pkg::*;
#(
    parameter int CMD_AW = 11
) (
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              m_unl1,
    output logic              m_unl2,
    output logic              m_pgm,
    output logic              m_ers,
    output logic              m_chip,
    output logic              m_auto,
    output logic              m_sect,
    output logic              m_susp,
    output logic              m_reset
);
    localparam logic [CMD_AW-1:0] ADDR_A = CMD_AW'(CA_FIRST);
    localparam logic [CMD_AW-1:0] ADDR_B = CMD_AW'(CA_SECOND);

    logic at_a;
    logic at_b;

    assign at_a    = wr_en && (cmd_addr == ADDR_A);
    assign at_b    = wr_en && (cmd_addr == ADDR_B);

    assign m_unl1  = at_a && (cmd_data == CB_UNLOCK1);
    assign m_unl2  = at_b && (cmd_data == CB_UNLOCK2);
    assign m_pgm   = at_a && (cmd_data == CB_PROGRAM);
    assign m_ers   = at_a && (cmd_data == CB_ERASE);
    assign m_chip  = at_a && (cmd_data == CB_CHIP);
    assign m_auto  = at_a && (cmd_data == CB_AUTOSEL);
    // data-only commands: any address
    assign m_sect  = wr_en && (cmd_data == CB_SECTOR);
    assign m_susp  = wr_en && (cmd_data == CB_SUSPEND);
    assign m_reset = wr_en && (cmd_data == CB_RESET);
endmodule

// File: rtl/fcd_win_timer.sv
module fcd_win_timer #(
    parameter int WIN_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fcd_sector_set.sv
module fcd_sector_set #(
    parameter int SECT_BITS = 3,
    localparam int N_SECT   = 1 << SECT_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 load_all,
    input  logic                 add,
    input  logic [SECT_BITS-1:0] sect_idx,
    input  logic [N_SECT-1:0]    prot_mask,
    output logic [N_SECT-1:0]    set_q
);
    logic [N_SECT-1:0] add_vec;

    generate
        for (genvar g = 0; g < N_SECT; g++) begin : g_dec
            assign add_vec[g] = (sect_idx == SECT_BITS'(g)) && !prot_mask[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
        end else if (clr) begin
            set_q <= '0;
        end else if (load_all) begin
            set_q <= ~prot_mask;
        end else if (add) begin
            set_q <= set_q | add_vec;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int  ADDR_W     = 19,
    parameter int  SECT_BITS  = 3,
    parameter int  CMD_AW     = 11,
    parameter int  WIN_CYCLES = 64,
    localparam int N_SECT     = 1 << SECT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [N_SECT-1:0] prot_mask,
    input  logic              alg_done,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [7:0]        pgm_data,
    output logic              chip_start,
    output logic              sect_start,
    output logic              susp_pulse,
    output logic              resume_pulse,
    output logic [N_SECT-1:0] erase_set,
    output logic [1:0]        read_sel
);
    fcd_state_e st, nxt;
    logic pend_win;

    logic m_unl1, m_unl2, m_pgm, m_ers, m_chip, m_auto, m_sect, m_susp, m_reset;
    logic go_pgm, go_chip, go_sect, go_susp, go_res;
    logic set_add, set_all, t_restart, t_expired;
    logic [SECT_BITS-1:0] wr_sect;
    logic wr_prot;

    assign wr_sect = wr_addr[ADDR_W-1 -: SECT_BITS];
    assign wr_prot = prot_mask[wr_sect];

    fcd_cmd_match #(.CMD_AW(CMD_AW)) u_match (
        .wr_en    (wr_en),
        .cmd_addr (wr_addr[CMD_AW-1:0]),
        .cmd_data (wr_data),
        .m_unl1   (m_unl1),
        .m_unl2   (m_unl2),
        .m_pgm    (m_pgm),
        .m_ers    (m_ers),
        .m_chip   (m_chip),
        .m_auto   (m_auto),
        .m_sect   (m_sect),
        .m_susp   (m_susp),
        .m_reset  (m_reset)
    );

    fcd_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == ST_SECT_WIN),
        .restart (t_restart),
        .expired (t_expired)
    );

    fcd_sector_set #(.SECT_BITS(SECT_BITS)) u_set (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (nxt == ST_IDLE),
        .load_all  (set_all),
        .add       (set_add),
        .sect_idx  (wr_sect),
        .prot_mask (prot_mask),
        .set_q     (erase_set)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            pend_win <= 1'b0;
        end else begin
            st <= nxt;
            if (go_susp) begin
                pend_win <= (st == ST_SECT_WIN);
            end
        end
    end

    // next state and actions
    always_comb begin
        nxt       = st;
        go_pgm    = 1'b0;
        go_chip   = 1'b0;
        go_sect   = 1'b0;
        go_susp   = 1'b0;
        go_res    = 1'b0;
        set_add   = 1'b0;
        set_all   = 1'b0;
        t_restart = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (m_unl1) nxt = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_en) nxt = m_unl2 ? ST_UNL2 : ST_IDLE;
            end
            ST_UNL2: begin
                if (wr_en) begin
                    if (m_pgm)       nxt = ST_PGM_WAIT;
                    else if (m_ers)  nxt = ST_ERS1;
                    else if (m_auto) nxt = ST_AUTOSEL;
                    else             nxt = ST_IDLE;
                end
            end
            ST_PGM_WAIT: begin
                if (wr_en) begin
                    if (!wr_prot) begin
                        go_pgm = 1'b1;
                        nxt    = ST_PGM_BUSY;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_ERS1: begin
                if (wr_en) nxt = m_unl1 ? ST_ERS2 : ST_IDLE;
            end
            ST_ERS2: begin
                if (wr_en) nxt = m_unl2 ? ST_ERS3 : ST_IDLE;
            end
            ST_ERS3: begin
                if (m_chip) begin
                    if (|(~prot_mask)) begin
                        go_chip = 1'b1;
                        set_all = 1'b1;
                        nxt     = ST_CHIP_BUSY;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else if (m_sect) begin
                    set_add   = 1'b1;
                    t_restart = 1'b1;
                    nxt       = ST_SECT_WIN;
                end else if (wr_en) begin
                    nxt = ST_IDLE;
                end
            end
            ST_AUTOSEL: begin
                if (m_reset) nxt = ST_IDLE;
            end
            ST_PGM_BUSY, ST_CHIP_BUSY: begin
                if (alg_done) nxt = ST_IDLE;
            end
            ST_SECT_WIN: begin
                if (m_sect) begin
                    set_add   = 1'b1;
                    t_restart = 1'b1;
                end else if (m_susp) begin
                    go_susp = 1'b1;
                    nxt     = ST_SUSP;
                end else if (wr_en) begin
                    nxt = ST_IDLE;
                end else if (t_expired) begin
                    if (|erase_set) begin
                        go_sect = 1'b1;
                        nxt     = ST_SECT_BUSY;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_SECT_BUSY: begin
                if (alg_done) begin
                    nxt = ST_IDLE;
                end else if (m_susp) begin
                    go_susp = 1'b1;
                    nxt     = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (m_sect) begin
                    go_res = 1'b1;
                    if (pend_win) begin
                        t_restart = 1'b1;
                        nxt       = ST_SECT_WIN;
                    end else begin
                        nxt = ST_SECT_BUSY;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_start    <= 1'b0;
            pgm_addr     <= '0;
            pgm_data     <= '0;
            chip_start   <= 1'b0;
            sect_start   <= 1'b0;
            susp_pulse   <= 1'b0;
            resume_pulse <= 1'b0;
            read_sel     <= RS_ARRAY;
        end else begin
            pgm_start    <= go_pgm;
            chip_start   <= go_chip;
            sect_start   <= go_sect;
            susp_pulse   <= go_susp;
            resume_pulse <= go_res;
            read_sel     <= mode_of(nxt);
            if (go_pgm) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int  SECT_BITS = 3,
    localparam int N_SECT    = 1 << SECT_BITS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [N_SECT-1:0]    prot_mask,
    input logic                 pgm_start,
    input logic [SECT_BITS-1:0] pgm_sect,
    input logic                 chip_start,
    input logic                 sect_start,
    input logic                 susp_pulse,
    input logic                 resume_pulse,
    input logic [N_SECT-1:0]    erase_set,
    input logic [1:0]           read_sel
);
    a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_start, chip_start, sect_start, susp_pulse, resume_pulse}));

    a_r3_pgm_single: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |=> !pgm_start);

    a_r2_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_start || chip_start || susp_pulse || resume_pulse) |-> $past(wr_en));

    a_r4_pgm_unprot: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |-> (($past(prot_mask) & (N_SECT'(1) << pgm_sect)) == '0));

    a_r5_chip_set: assert property (@(posedge clk) disable iff (!rst_n)
        chip_start |-> ((erase_set == ~$past(prot_mask)) && (erase_set != '0)));

    a_r6_sect_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        sect_start |-> (erase_set != '0));

    a_r9_susp_array: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |-> (read_sel == 2'd0));

    a_r10_resume_status: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> (read_sel == 2'd1));
endmodule

bind flash_cmd_decoder fcd_checker #(.SECT_BITS(SECT_BITS)) u_fcd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .prot_mask    (prot_mask),
    .pgm_start    (pgm_start),
    .pgm_sect     (pgm_addr[ADDR_W-1 -: SECT_BITS]),
    .chip_start   (chip_start),
    .sect_start   (sect_start),
    .susp_pulse   (susp_pulse),
    .resume_pulse (resume_pulse),
    .erase_set    (erase_set),
    .read_sel     (read_sel)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  prot_mask = '0;
    logic        alg_done = 1'b0;
    logic        pgm_start, chip_start, sect_start, susp_pulse, resume_pulse;
    logic [18:0] pgm_addr;
    logic [7:0]  pgm_data, erase_set;
    logic [1:0]  read_sel;

    flash_cmd_decoder #(.WIN_CYCLES(W)) u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prot_mask(prot_mask), .alg_done(alg_done),
        .pgm_start(pgm_start), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .chip_start(chip_start), .sect_start(sect_start),
        .susp_pulse(susp_pulse), .resume_pulse(resume_pulse),
        .erase_set(erase_set), .read_sel(read_sel)
    );

    always #10 clk = ~clk;

    int nchk = 0, nfail = 0;
    int cyc = 0, last_wr = 0;
    int n_pgm = 0, n_chip = 0, n_sect = 0, n_susp = 0, n_res = 0;
    int sect_cyc = 0;
    logic [18:0] cap_addr;
    logic [7:0]  cap_data, cap_chip_set, cap_sect_set;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (pgm_start)    begin n_pgm <= n_pgm + 1; cap_addr <= pgm_addr; cap_data <= pgm_data; end
        if (chip_start)   begin n_chip <= n_chip + 1; cap_chip_set <= erase_set; end
        if (sect_start)   begin n_sect <= n_sect + 1; cap_sect_set <= erase_set; sect_cyc <= cyc + 1; end
        if (susp_pulse)   n_susp <= n_susp + 1;
        if (resume_pulse) n_res <= n_res + 1;
    end

    function automatic bit exp_pgm_ok(input logic [7:0] pm, input logic [18:0] a);
        return !pm[a[18:16]];
    endfunction

    function automatic logic [7:0] sect_bit(input logic [18:0] a);
        return 8'(1) << a[18:16];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        #1;
        wr_en = 1'b0;
        last_wr = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        alg_done = 1'b1;
        @(negedge clk);
        #1;
        alg_done = 1'b0;
    endtask

    task automatic unlock();
        wr(19'h00555, 8'hAA);
        wr(19'h002AA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(19'h00555, 8'h80);
        unlock();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int p0, s0, u0, r0, c0;
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 read_sel", read_sel, 0);
        chk("R1 erase_set", erase_set, 0);
        chk("R1 pulses", {pgm_start, chip_start, sect_start, susp_pulse, resume_pulse}, 0);

        // R3 program, R9 suspend ignored, R12 done
        unlock(); wr(19'h00555, 8'hA0); wr(19'h31234, 8'h5A);
        chk("R3 pgm count", n_pgm, 1);
        chk("R3 pgm addr", cap_addr, 19'h31234);
        chk("R3 pgm data", cap_data, 8'h5A);
        chk("R3 status", read_sel, 1);
        wr(19'h00000, 8'hB0);
        chk("R9 no susp in pgm", n_susp, 0);
        chk("R9 status kept", read_sel, 1);
        done_pulse();
        chk("R12 back to array", read_sel, 0);

        // R4 protected target
        prot_mask = 8'h08;
        unlock(); wr(19'h00555, 8'hA0); wr(19'h30000, 8'h11);
        chk("R4 no pgm", n_pgm, 1);
        chk("R4 read_sel", read_sel, 0);

        // R2 only low address bits decoded
        prot_mask = 8'h00;
        wr(19'h7D555, 8'hAA); wr(19'h1AAAA, 8'h55); wr(19'h44555, 8'hA0); wr(19'h00010, 8'hC3);
        chk("R2 high bits ignored", n_pgm, 2);
        done_pulse();

        // R2 broken sequence
        wr(19'h00555, 8'hAA); wr(19'h002AB, 8'h55); wr(19'h00555, 8'hA0); wr(19'h00020, 8'h77);
        chk("R2 broken no pgm", n_pgm, 2);
        chk("R2 broken read_sel", read_sel, 0);

        // R13 reset mid-sequence
        unlock(); wr(19'h00123, 8'hF0); wr(19'h00555, 8'hA0); wr(19'h00040, 8'h99);
        chk("R13 no pgm", n_pgm, 2);
        chk("R13 read_sel", read_sel, 0);

        // R11 identification
        unlock(); wr(19'h00555, 8'h90);
        chk("R11 ident", read_sel, 2);
        wr(19'h00555, 8'hAA);
        chk("R11 stays ident", read_sel, 2);
        wr(19'h00000, 8'hF0);
        chk("R11 exit", read_sel, 0);

        // R5 chip erase
        prot_mask = 8'h81;
        erase_prefix(); wr(19'h00555, 8'h10);
        chk("R5 chip pulse", n_chip, 1);
        chk("R5 chip set", cap_chip_set, 8'h7E);
        chk("R5 status", read_sel, 1);
        wr(19'h00000, 8'hB0);
        chk("R9 no susp in chip", n_susp, 0);
        done_pulse();
        chk("R12 set cleared", erase_set, 0);
        prot_mask = 8'hFF;
        erase_prefix(); wr(19'h00555, 8'h10);
        chk("R5 all protected", n_chip, 1);
        chk("R5 all protected mode", read_sel, 0);

        // R6 R7 sector erase with queueing, R9 R10 suspend/resume
        prot_mask = 8'h04;
        erase_prefix(); wr(19'h20000, 8'h30);
        chk("R6 protected not queued", erase_set, 0);
        wr(19'h50000, 8'h30); wr(19'h000FF, 8'h30);
        chk("R7 queued set", erase_set, 8'h21);
        chk("R6 window status", read_sel, 1);
        s0 = n_sect; p0 = last_wr;
        idle(W + 2);
        chk("R6 start count", n_sect, s0 + 1);
        chk("R6 start timing", sect_cyc, p0 + W);
        chk("R6 start set", cap_sect_set, 8'h21);
        wr(19'h60000, 8'hB0);
        chk("R9 susp pulse", n_susp, 1);
        chk("R9 susp array", read_sel, 0);
        wr(19'h00555, 8'hA0);
        done_pulse();
        chk("R12 done ignored in susp", erase_set, 8'h21);
        chk("R10 other write ignored", n_res, 0);
        wr(19'h00000, 8'h30);
        chk("R10 resume pulse", n_res, 1);
        chk("R10 resume status", read_sel, 1);
        idle(W + 2);
        chk("R10 no restart of erase", n_sect, s0 + 1);
        done_pulse();
        chk("R12 sector done", erase_set, 0);

        // R6 empty set
        prot_mask = 8'h02;
        s0 = n_sect;
        erase_prefix(); wr(19'h10000, 8'h30);
        idle(W + 3);
        chk("R6 empty no start", n_sect, s0);
        chk("R6 empty back to array", read_sel, 0);

        // R8 abort in window
        prot_mask = 8'h00;
        erase_prefix(); wr(19'h60000, 8'h30); wr(19'h00555, 8'h80);
        chk("R8 abort mode", read_sel, 0);
        chk("R8 abort set", erase_set, 0);
        idle(W + 3);
        chk("R8 no start", n_sect, s0);

        // R7 coincidence: add on the expiry edge
        erase_prefix(); wr(19'h00000, 8'h30);
        idle(W - 2);
        wr(19'h70000, 8'h30);
        chk("R7 no start on add edge", n_sect, s0);
        chk("R7 set grown", erase_set, 8'h81);
        p0 = last_wr;
        idle(W + 2);
        chk("R7 start after restart", sect_cyc, p0 + W);
        chk("R7 start count", n_sect, s0 + 1);
        done_pulse();

        // R10 suspend inside window
        s0 = n_sect; u0 = n_susp; r0 = n_res;
        erase_prefix(); wr(19'h40000, 8'h30);
        idle(2);
        wr(19'h00000, 8'hB0);
        chk("R9 susp in window", n_susp, u0 + 1);
        idle(W + 2);
        chk("R10 no start while suspended", n_sect, s0);
        wr(19'h00000, 8'h30);
        chk("R10 resume count", n_res, r0 + 1);
        p0 = last_wr;
        idle(W + 2);
        chk("R10 window reopened", sect_cyc, p0 + W);
        chk("R10 set kept", cap_sect_set, 8'h10);
        done_pulse();

        // random programs, some broken (R3 R4 R2)
        for (int i = 0; i < 40; i++) begin
            logic [18:0] a;
            logic [7:0]  d;
            bit brk, ok;
            prot_mask = 8'($urandom);
            a   = 19'($urandom);
            d   = 8'($urandom);
            brk = ($urandom % 4) == 0;
            p0  = n_pgm;
            c0  = n_chip;
            if (brk) begin
                wr(19'h00555, 8'hAA);
                wr(19'h002AA, 8'h56);
                wr(19'h00555, 8'hA0);
                wr(a, d);
                chk("R2 random break", n_pgm, p0);
            end else begin
                unlock(); wr(19'h00555, 8'hA0); wr(a, d);
                ok = exp_pgm_ok(prot_mask, a);
                chk("R4 random protect", n_pgm, p0 + (ok ? 1 : 0));
                if (ok) begin
                    chk("R3 random addr", cap_addr, a);
                    chk("R3 random data", cap_data, d);
                    chk("R4 random sector free", int'(sect_bit(a) & prot_mask), 0);
                    done_pulse();
                end
            end
            chk("R1 random idle mode", read_sel, 0);
            chk("R5 no stray chip", n_chip, c0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule